// File: doc/BRIEF.md
# Sampling-Phase Window Centre Selector

After a receive clock phase sweep, each tap position holds a pass or fail result. This block takes those results and picks the sampling tap that sits in the middle of the widest passing window. The caller supplies a pass vector that covers the sweep twice, so its length is twice the number of taps. A passing window that wraps from the last tap back to tap zero therefore shows up as one unbroken run. The block walks the vector one bit per clock, from bit 0 upward. It remembers the longest run of consecutive passes. At the end it reports the centre of that run, folded back into the tap range. If no run of at least three passes exists, it reports an error instead.

A scan starts with a one-cycle start strobe while the block is idle. The vector and the tap count are captured on that edge. The result appears together with a one-cycle done pulse. The tap and error outputs then keep their values until the next accepted start.

Top module: `tune_window_sel`

## Requirements
- R1: A start strobe is accepted only while the block is idle. It captures `pass_vec_i` and `tap_count_i`. A strobe during a scan or during its result cycle is ignored, and changes on the data inputs after acceptance have no effect on that scan.
- R2: For tap count N, `done_o` rises 2N+1 clock edges after the accepting edge and stays high for exactly one cycle.
- R3: Bit i of `pass_vec_i` is 1 when position i passed. Positions 0 to 2N-1 are scanned in ascending order. The reported tap comes from the longest run of consecutive 1 bits.
- R4: When two runs have the same greatest length, the run that starts at the lower bit position is chosen.
- R5: A passing window that crosses from tap N-1 to tap 0 is handled as a single run, because the vector holds two consecutive passes over the taps.
- R6: A run that is still open at bit 2N-1 takes part in the selection like any other run.
- R7: If the longest run is shorter than 3 bits, `error_o` is 1 and `tap_o` is 0. A run of exactly 3 is accepted.
- R8: With the run spanning bits s..e, `tap_o` = ((s+e)/2, rounded down) mod N.
- R9: `tap_o` and `error_o` are cleared to 0 on an accepted start. They are loaded on the done cycle and hold that value until the next accepted start.
- R10: After reset, `done_o`, `tap_o` and `error_o` are 0.
- R11: N may be any value from 1 to MAX_TAPS. Bits of `pass_vec_i` at positions 2N and above have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| pass_vec_i | input | 2*MAX_TAPS | Sweep results, bit i = position i passed |
| tap_count_i | input | $clog2(MAX_TAPS+1) | Number of taps N (1..MAX_TAPS) |
| done_o | output | 1 | One-cycle result strobe |
| tap_o | output | $clog2(MAX_TAPS+1) | Selected tap |
| error_o | output | 1 | No passing window of at least 3 |

## Verification
A wrong run counter or best-run record changes nothing at the ports until the done cycle. At that cycle it shows up as a wrong tap or a wrong error flag, about 2N+1 cycles after start. For that reason each vector is built so that a single off-by-one in run start, run end, tie handling or the final open-run comparison changes the reported tap. A bad scan index or limit shows up as done arriving in the wrong cycle. The outputs are compared against a behavioural model on every clock, so a late pulse is caught the moment it appears, and so is a result that drifts while idle.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_RUN  = 2'd1,
    SCAN_EMIT = 2'd2
  } scan_state_e;
endpackage

// File: rtl/tws_scan_ctrl.sv
// Sequencer: captures the vector on start and shifts it out one bit per clock.
module tws_scan_ctrl #(
  parameter int MAX_TAPS = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start_i,
  input  logic [2*MAX_TAPS-1:0]                 vec_i,
  input  logic [$clog2(MAX_TAPS+1)-1:0]         count_i,
  output logic                                  accept_o,
  output logic                                  step_o,
  output logic                                  bit_o,
  output logic                                  last_o,
  output logic [$clog2(MAX_TAPS+1):0]           idx_o,
  output logic                                  emit_o,
  output logic [$clog2(MAX_TAPS+1)-1:0]         count_o
);
  import tws_pkg::*;

  localparam int VEC_W = 2 * MAX_TAPS;
  localparam int CNT_W = $clog2(MAX_TAPS + 1);
  localparam int IDX_W = CNT_W + 1;

  scan_state_e        state_q, state_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [IDX_W-1:0]   lim_q, lim_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               at_last;

  assign at_last = (idx_q == lim_q);

  always_comb begin
    state_d = state_q;
    vec_d   = vec_q;
    idx_d   = idx_q;
    lim_d   = lim_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start_i) begin
          state_d = SCAN_RUN;
          vec_d   = vec_i;
          idx_d   = '0;
          cnt_d   = count_i;
          // last index 2N-1 = {N-1, 1}
          lim_d   = {count_i - CNT_W'(1), 1'b1};
        end
      end
      SCAN_RUN: begin
        vec_d = vec_q >> 1;
        idx_d = idx_q + IDX_W'(1);
        if (at_last) state_d = SCAN_EMIT;
      end
      SCAN_EMIT: state_d = SCAN_IDLE;
      default:   state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      vec_q   <= '0;
      idx_q   <= '0;
      lim_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      vec_q   <= vec_d;
      idx_q   <= idx_d;
      lim_q   <= lim_d;
      cnt_q   <= cnt_d;
    end
  end

  assign accept_o = (state_q == SCAN_IDLE) && start_i;
  assign step_o   = (state_q == SCAN_RUN);
  assign emit_o   = (state_q == SCAN_EMIT);
  assign bit_o    = vec_q[0];
  assign last_o   = at_last;
  assign idx_o    = idx_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/tws_run_track.sv
// Tracks the current pass run and keeps the longest one seen so far.
module tws_run_track #(
  parameter int MAX_TAPS = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clear_i,
  input  logic                               step_i,
  input  logic                               bit_i,
  input  logic                               last_i,
  input  logic [$clog2(MAX_TAPS+1):0]        idx_i,
  output logic [$clog2(MAX_TAPS+1):0]        best_len_o,
  output logic [$clog2(MAX_TAPS+1):0]        best_start_o,
  output logic [$clog2(MAX_TAPS+1):0]        best_end_o
);
  localparam int CNT_W = $clog2(MAX_TAPS + 1);
  localparam int IDX_W = CNT_W + 1;

  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] best_len_q, best_len_d;
  logic [IDX_W-1:0] best_start_q, best_start_d;
  logic [IDX_W-1:0] best_end_q, best_end_d;

  logic [IDX_W-1:0] cand_len, cand_start, cand_end;
  logic             closing, take;

  // A run closes on a failing bit, or on the final bit (open run).
  assign closing    = step_i && (!bit_i || last_i);
  assign cand_len   = bit_i ? (cur_q + IDX_W'(1)) : cur_q;
  assign cand_end   = bit_i ? idx_i : (idx_i - IDX_W'(1));
  assign cand_start = idx_i - cur_q;
  // strict comparison: earlier run wins a tie
  assign take       = closing && (cand_len > best_len_q);

  always_comb begin
    cur_d        = cur_q;
    best_len_d   = best_len_q;
    best_start_d = best_start_q;
    best_end_d   = best_end_q;
    if (clear_i) begin
      cur_d        = '0;
      best_len_d   = '0;
      best_start_d = '0;
      best_end_d   = '0;
    end else if (step_i) begin
      cur_d = bit_i ? (cur_q + IDX_W'(1)) : '0;
      if (take) begin
        best_len_d   = cand_len;
        best_start_d = cand_start;
        best_end_d   = cand_end;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q        <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
      best_end_q   <= '0;
    end else begin
      cur_q        <= cur_d;
      best_len_q   <= best_len_d;
      best_start_q <= best_start_d;
      best_end_q   <= best_end_d;
    end
  end

  assign best_len_o   = best_len_q;
  assign best_start_o = best_start_q;
  assign best_end_o   = best_end_q;
endmodule

// File: rtl/tws_centre.sv
// Midpoint of the best run, folded into 0..N-1, plus the too-short check.
module tws_centre #(
  parameter int MAX_TAPS = 16,
  parameter int MIN_RUN  = 3
) (
  input  logic [$clog2(MAX_TAPS+1):0]     best_len_i,
  input  logic [$clog2(MAX_TAPS+1):0]     best_start_i,
  input  logic [$clog2(MAX_TAPS+1):0]     best_end_i,
  input  logic [$clog2(MAX_TAPS+1)-1:0]   count_i,
  output logic [$clog2(MAX_TAPS+1)-1:0]   tap_o,
  output logic                            err_o
);
  localparam int CNT_W = $clog2(MAX_TAPS + 1);
  localparam int IDX_W = CNT_W + 1;

  logic [IDX_W:0]   sum;
  logic [IDX_W-1:0] half, cnt_ext, fold;

  assign sum     = {1'b0, best_start_i} + {1'b0, best_end_i};
  assign half    = IDX_W'(sum >> 1);
  assign cnt_ext = IDX_W'(count_i);
  // half < 2N always, so one conditional subtract is a full modulo
  assign fold    = (half >= cnt_ext) ? (half - cnt_ext) : half;
  assign err_o   = (best_len_i < IDX_W'(MIN_RUN));
  assign tap_o   = err_o ? '0 : CNT_W'(fold);
endmodule

// File: rtl/tune_window_sel.sv
module tune_window_sel #(
  parameter int MAX_TAPS = 16,
  parameter int MIN_RUN  = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  input  logic [2*MAX_TAPS-1:0]               pass_vec_i,
  input  logic [$clog2(MAX_TAPS+1)-1:0]       tap_count_i,
  output logic                                done_o,
  output logic [$clog2(MAX_TAPS+1)-1:0]       tap_o,
  output logic                                error_o
);
  localparam int CNT_W = $clog2(MAX_TAPS + 1);
  localparam int IDX_W = CNT_W + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             accept, step, cur_bit, is_last, emit;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_lat;
  logic [IDX_W-1:0] best_len, best_start, best_end;
  logic [CNT_W-1:0] sel_tap;
  logic             sel_err;

  tws_scan_ctrl #(.MAX_TAPS(MAX_TAPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .vec_i    (pass_vec_i),
    .count_i  (tap_count_i),
    .accept_o (accept),
    .step_o   (step),
    .bit_o    (cur_bit),
    .last_o   (is_last),
    .idx_o    (idx),
    .emit_o   (emit),
    .count_o  (cnt_lat)
  );

  tws_run_track #(.MAX_TAPS(MAX_TAPS)) u_track (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clear_i      (accept),
    .step_i       (step),
    .bit_i        (cur_bit),
    .last_i       (is_last),
    .idx_i        (idx),
    .best_len_o   (best_len),
    .best_start_o (best_start),
    .best_end_o   (best_end)
  );

  tws_centre #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(MIN_RUN)) u_centre (
    .best_len_i   (best_len),
    .best_start_i (best_start),
    .best_end_i   (best_end),
    .count_i      (cnt_lat),
    .tap_o        (sel_tap),
    .err_o        (sel_err)
  );

  logic             done_q, done_d;
  logic [CNT_W-1:0] tap_q, tap_d;
  logic             err_q, err_d;

  always_comb begin
    done_d = emit;
    tap_d  = tap_q;
    err_d  = err_q;
    if (accept) begin
      tap_d = '0;
      err_d = 1'b0;
    end else if (emit) begin
      tap_d = sel_tap;
      err_d = sel_err;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      tap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      tap_q  <= tap_d;
      err_q  <= err_d;
    end
  end

  assign done_o  = done_q;
  assign tap_o   = tap_q;
  assign error_o = err_q;
endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             emit,
  input logic             done,
  input logic [CNT_W-1:0] tap,
  input logic             err,
  input logic [CNT_W-1:0] cnt
);
  assert_accept_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(emit));

  assert_err_no_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (tap == '0));

  assert_tap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (tap < cnt));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !emit) |=> ($stable(tap) && $stable(err)));
endmodule

bind tune_window_sel tws_checker #(.CNT_W($clog2(MAX_TAPS+1))) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .accept (accept),
  .emit   (emit),
  .done   (done_o),
  .tap    (tap_o),
  .err    (error_o),
  .cnt    (cnt_lat)
);

// File: tb/sim_tune_window_sel.sv
`timescale 1ns/1ps
module sim_tune_window_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] pass_vec_i;
  logic [4:0]  tap_count_i;
  logic        done_o;
  logic [4:0]  tap_o;
  logic        error_o;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;

  always #2 clk = ~clk;

  tune_window_sel #(.MAX_TAPS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pass_vec_i(pass_vec_i),
    .tap_count_i(tap_count_i), .done_o(done_o), .tap_o(tap_o), .error_o(error_o)
  );

  // behavioural answer straight from the selection rules
  function automatic void ref_pick(input logic [31:0] v, input int n,
                                   output int tap, output bit err);
    int best = 0, bs = 0, be = 0, run = 0;
    for (int i = 0; i < 2 * n; i++) begin
      if (v[i]) run++;
      else begin
        if (run > best) begin best = run; bs = i - run; be = i - 1; end
        run = 0;
      end
    end
    if (run > best) begin best = run; bs = 2 * n - run; be = 2 * n - 1; end
    err = (best < 3);
    tap = err ? 0 : ((bs + be) / 2) % n;
  endfunction

  // cycle model
  bit m_busy;
  int m_left;
  int p_tap;
  bit p_err;
  bit e_done;
  int e_tap;
  bit e_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; e_done = 0; e_tap = 0; e_err = 0;
    end else begin
      e_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1;
          m_left = 2 * int'(tap_count_i) + 1;
          e_tap = 0; e_err = 0;
          ref_pick(pass_vec_i, int'(tap_count_i), p_tap, p_err);
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; e_done = 1; e_tap = p_tap; e_err = p_err;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      checks++;
      if (done_o !== e_done) begin
        fails++;
        $display("FAIL R2 per-cycle done: got %0b expected %0b", done_o, e_done);
      end
      checks++;
      if (int'(tap_o) != e_tap || error_o !== e_err) begin
        fails++;
        $display("FAIL R9 per-cycle result: got tap=%0d err=%0b expected tap=%0d err=%0b",
                 tap_o, error_o, e_tap, e_err);
      end
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic do_case(input int n, input logic [31:0] v, input int etap,
                         input bit eerr, input string tag, input bit poke);
    int lat;
    @(negedge clk);
    tap_count_i = 5'(n); pass_vec_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; lat = 1;
    if (poke) begin
      repeat (3) begin @(negedge clk); lat++; end
      pass_vec_i = 32'hFFFF_FFFF; tap_count_i = 5'd16; start_i = 1'b1;
      @(negedge clk); lat++;
      start_i = 1'b0;
    end
    while (!done_o && lat < 80) begin @(negedge clk); lat++; end
    check(lat == 2 * n + 2, {tag, " R2 latency"}, lat, 2 * n + 2);
    check(int'(tap_o) == etap, {tag, " tap"}, int'(tap_o), etap);
    check(error_o == eerr, {tag, " error"}, int'(error_o), int'(eerr));
    repeat (5) @(negedge clk);
    check(int'(tap_o) == etap && error_o == eerr && !done_o,
          {tag, " R9 hold"}, int'(tap_o), etap);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; pass_vec_i = '0; tap_count_i = 5'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done_o && tap_o == 0 && !error_o, "R10 reset state",
          int'({done_o, error_o, tap_o}), 0);
    mon_en = 1'b1;

    do_case(8,  32'h0000_067C, 4,  0, "R3 single longest", 0);
    do_case(8,  32'h0000_03E7, 7,  0, "R3 later longer", 0);
    do_case(8,  32'h0000_1C0E, 2,  0, "R4 tie earliest", 0);
    do_case(8,  32'h0000_8787, 0,  0, "R5 wrap window", 0);
    do_case(4,  32'h0000_00E3, 2,  0, "R6 R8 open run folded", 0);
    do_case(8,  32'h0000_1863, 0,  1, "R7 runs of two", 0);
    do_case(8,  32'h0000_0070, 5,  0, "R7 exactly three", 0);
    do_case(16, 32'h0000_0000, 0,  1, "R7 all fail", 0);
    do_case(16, 32'hFFFF_FFFF, 15, 0, "R8 all pass", 0);
    do_case(4,  32'hFFFF_FF0E, 2,  0, "R11 upper bits ignored", 0);
    do_case(1,  32'hFFFF_FFFF, 0,  1, "R11 one tap", 0);
    do_case(2,  32'h0000_000F, 1,  0, "R11 two taps", 0);
    do_case(8,  32'h0000_007C, 4,  0, "R1 start during scan", 1);
    do_case(8,  32'h0000_8787, 0,  0, "R9 cleared and reloaded", 0);

    mon_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule